// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits beside a flash array's program/erase controller and produces the status bits the array places on the data bus while an embedded operation runs or sits suspended. The controller reports its current operation state, the per-sector erase selection and the sector of the current read address. The block then keeps two toggle bits, a timeout flag and a ready/busy line. The activity toggle (bit 6) flips on every completed read while the device is actively programming or erasing, and holds still during erase suspend. The erase-sector toggle (bit 2) flips only on reads that land in a sector chosen for erase, and it keeps doing so while the erase is suspended. Reading both bits tells a host whether an erase is active or suspended, and which sectors it covers.

A read cycle is open while output-enable and chip-enable are both low. It closes when either one rises, so a host may frame reads with either strobe. Toggle bits advance only after the controller signals the rising edge of the final write-enable pulse of a command. A pulse-limit-exceeded event from the controller sets the timeout bit (bit 5) and holds the line busy. A later reset command clears the bit and reports where the device returns: plain array read, or erase-suspend read when the failed program ran inside an erase suspend.

All pins are plain control and status lines. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `flash_opstat_gen`

## Requirements
- R1: After reset, status6, status2 and status5 are 0, ready is 1 and ret_valid is 0.
- R2: op_state uses the codes IDLE=0, PROGRAM=1, ERASE=2, ERASE_SUSPENDED=3 and SUSPENDED_PROGRAM=4. While the block is armed and op_state is 1, 2 or 4, status6 inverts on the clock edge that ends each read cycle.
- R3: A read cycle is open while oe_n and ce_n are both low. It ends when either one rises. Each read cycle advances a toggle bit once, whichever strobe ends it.
- R4: status6 holds its value while op_state is IDLE or ERASE_SUSPENDED.
- R5: status2 inverts at the end of a read only when the block is armed, op_state is ERASE or ERASE_SUSPENDED, rd_sector is below NUM_SECTORS, and bit rd_sector of erase_sel is 1. Otherwise status2 holds.
- R6: The block arms on a cmd_we_rise pulse and disarms when op_state is IDLE and status5 is 0. While the block is not armed, neither toggle bit moves.
- R7: A limit_hit pulse while op_state is 1, 2 or 4 sets status5 at the next edge. status5 stays 1 until a reset command, and ready reads 0 the whole time status5 is 1.
- R8: A reset_cmd pulse while status5 is 1 clears status5 at the next edge. It also raises ret_valid for exactly one cycle, with ret_esusp=1 if and only if the fault arose in SUSPENDED_PROGRAM. A reset_cmd pulse while status5 is 0 leaves ret_valid at 0.
- R9: ready is registered. It reads 0 one cycle after op_state becomes 1, 2 or 4, and 1 one cycle after op_state becomes 0 or 3 with no fault held. Successful completion is signalled by op_state leaving a busy code.
- R10: A limit_hit pulse while op_state is IDLE or ERASE_SUSPENDED is ignored, and status5 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Controller operation state code |
| cmd_we_rise | input | 1 | Pulse at the rising edge of the final command write-enable |
| erase_sel | input | NUM_SECTORS | Per-sector erase-selected mask |
| rd_sector | input | SECT_W | Sector index of the current read address |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| limit_hit | input | 1 | Internal pulse-count limit exceeded event |
| reset_cmd | input | 1 | Reset command strobe |
| status6 | output | 1 | Activity toggle bit |
| status5 | output | 1 | Timing-limit-exceeded bit |
| status2 | output | 1 | Erase-sector toggle bit |
| ready | output | 1 | 1 = ready, 0 = busy |
| ret_valid | output | 1 | One-cycle pulse when a reset command clears a fault |
| ret_esusp | output | 1 | With ret_valid: 1 = return to erase-suspend read, 0 = array read |

## Verification
The bench builds the block with NUM_SECTORS=6. The sector index is then 3 bits wide, so codes 6 and 7 exist on the pins but name no sector. This lets the bench check that out-of-range reads leave the erase-sector toggle still, even with a fully set mask. The mask 6'b000101 places selected and unselected sectors next to each other, so one erase can show both toggle behaviours across reads that differ only in address.

// File: rtl/flash_opstat_pkg.sv
package flash_opstat_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROGRAM   = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ESUSP     = 3'd3,
    OP_ESUSP_PRG = 3'd4
  } op_state_e;

  // Array busy: an embedded algorithm is running.
  function automatic logic op_is_busy(op_state_e s);
    return (s == OP_PROGRAM) || (s == OP_ERASE) || (s == OP_ESUSP_PRG);
  endfunction

  // Erase context: an erase is active or suspended.
  function automatic logic op_in_erase(op_state_e s);
    return (s == OP_ERASE) || (s == OP_ESUSP);
  endfunction

endpackage

// File: rtl/flash_rd_cycle.sv
module flash_rd_cycle (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic ce_n,
  output logic rd_end
);
  logic rd_open;
  logic rd_open_q;

  assign rd_open = ~oe_n & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_open_q <= 1'b0;
    else        rd_open_q <= rd_open;
  end

  // Whichever strobe rises first closes the cycle.
  assign rd_end = rd_open_q & ~rd_open;

  // R3: a read end cannot repeat on consecutive cycles
  a_r3_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !rd_end);
endmodule

// File: rtl/flash_sector_hit.sv
module flash_sector_hit #(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic [NUM_SECTORS-1:0] mask,
  input  logic [SECT_W-1:0]      sector,
  output logic                   hit
);
  logic [NUM_SECTORS-1:0] match;

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    assign match[g] = mask[g] && (sector == SECT_W'(g));
  end

  // Indices at or above NUM_SECTORS match no lane.
  assign hit = |match;

  always_comb begin
    a_r5_hit_onehot: assert ($onehot0(match));
  end
endmodule

// File: rtl/flash_tbit.sv
module flash_tbit (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (adv) q <= ~q;
  end

  // R2: each advance inverts the bit
  a_r2_flip: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (q != $past(q)));
  // R5: no advance, no change
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));
endmodule

// File: rtl/flash_fault_trk.sv
module flash_fault_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic in_esp,
  input  logic limit_hit,
  input  logic reset_cmd,
  output logic fault,
  output logic fault_nxt,
  output logic ret_valid,
  output logic ret_esusp
);
  logic src_esp;

  // Reset command takes precedence over a same-cycle limit event.
  assign fault_nxt = reset_cmd ? 1'b0 : (fault | (limit_hit & busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault     <= 1'b0;
      src_esp   <= 1'b0;
      ret_valid <= 1'b0;
      ret_esusp <= 1'b0;
    end else begin
      fault     <= fault_nxt;
      ret_valid <= reset_cmd & fault;
      if (!fault && fault_nxt)    src_esp   <= in_esp;
      if (reset_cmd && fault)     ret_esusp <= src_esp;
    end
  end

  // R7: a fault persists until a reset command
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !reset_cmd) |=> fault);
  // R8: the return report is a single-cycle pulse
  a_r8_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !ret_valid);
  // R10: limit events outside a busy state are ignored
  a_r10_limit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_hit && !busy && !fault) |=> !fault);
endmodule

// File: rtl/flash_opstat_gen.sv
module flash_opstat_gen
  import flash_opstat_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             op_state,
  input  logic                   cmd_we_rise,
  input  logic [NUM_SECTORS-1:0] erase_sel,
  input  logic [SECT_W-1:0]      rd_sector,
  input  logic                   oe_n,
  input  logic                   ce_n,
  input  logic                   limit_hit,
  input  logic                   reset_cmd,
  output logic                   status6,
  output logic                   status5,
  output logic                   status2,
  output logic                   ready,
  output logic                   ret_valid,
  output logic                   ret_esusp
);
  op_state_e st;
  logic busy, rd_end, sec_hit, armed;
  logic fault, fault_nxt, adv6, adv2;

  assign st   = op_state_e'(op_state);
  assign busy = op_is_busy(st);

  flash_rd_cycle u_rd (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n), .rd_end(rd_end)
  );

  flash_sector_hit #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_hit (
    .mask(erase_sel), .sector(rd_sector), .hit(sec_hit)
  );

  flash_fault_trk u_fault (
    .clk(clk), .rst_n(rst_n), .busy(busy), .in_esp(st == OP_ESUSP_PRG),
    .limit_hit(limit_hit), .reset_cmd(reset_cmd),
    .fault(fault), .fault_nxt(fault_nxt),
    .ret_valid(ret_valid), .ret_esusp(ret_esusp)
  );

  // Status becomes meaningful only after the final command write strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        armed <= 1'b0;
    else if (cmd_we_rise)              armed <= 1'b1;
    else if (st == OP_IDLE && !fault)  armed <= 1'b0;
  end

  assign adv6 = rd_end & armed & busy;
  assign adv2 = rd_end & armed & op_in_erase(st) & sec_hit;

  flash_tbit u_t6 (.clk(clk), .rst_n(rst_n), .adv(adv6), .q(status6));
  flash_tbit u_t2 (.clk(clk), .rst_n(rst_n), .adv(adv2), .q(status2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b1;
    else        ready <= ~(busy | fault_nxt);
  end

  assign status5 = fault;

  // R4: the activity toggle is frozen in idle and erase suspend
  a_r4_t6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OP_IDLE || st == OP_ESUSP) |=> $stable(status6));
  // R6: nothing toggles while disarmed
  a_r6_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !cmd_we_rise) |=> ($stable(status6) && $stable(status2)));
  // R7: a held fault keeps the line busy
  a_r7_busy_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    status5 |-> !ready);
  // R9: a busy state drives busy on the next cycle
  a_r9_busy_follow: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ready);
endmodule

// File: tb/flash_opstat_gen_tb_top.sv
module flash_opstat_gen_tb_top;
  localparam int NS = 6;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_state = 3'd0;
  logic cmd_we_rise = 1'b0;
  logic [NS-1:0] erase_sel = '0;
  logic [SW-1:0] rd_sector = '0;
  logic oe_n = 1'b1, ce_n = 1'b1, limit_hit = 1'b0, reset_cmd = 1'b0;
  logic status6, status5, status2, ready, ret_valid, ret_esusp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_opstat_gen #(.NUM_SECTORS(NS), .SECT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .cmd_we_rise(cmd_we_rise),
    .erase_sel(erase_sel), .rd_sector(rd_sector), .oe_n(oe_n), .ce_n(ce_n),
    .limit_hit(limit_hit), .reset_cmd(reset_cmd),
    .status6(status6), .status5(status5), .status2(status2), .ready(ready),
    .ret_valid(ret_valid), .ret_esusp(ret_esusp)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_state(logic [2:0] s);
    @(negedge clk); op_state = s;
    @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); cmd_we_rise = 1'b1;
    @(negedge clk); cmd_we_rise = 1'b0;
  endtask

  // close_by_ce: 1 = chip enable rises first, 0 = output enable rises first
  task automatic read_cycle(logic [SW-1:0] sec, bit close_by_ce);
    @(negedge clk); rd_sector = sec; oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    if (close_by_ce) ce_n = 1'b1; else oe_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status6", status6, 1'b0);
    chk("R1 status2", status2, 1'b0);
    chk("R1 status5", status5, 1'b0);
    chk("R1 ready", ready, 1'b1);
    chk("R1 ret_valid", ret_valid, 1'b0);
  endtask

  task automatic t_unarmed();
    logic o6;
    set_state(3'd1);
    chk("R9 busy after program", ready, 1'b0);
    o6 = status6;
    read_cycle(3'd0, 0);
    chk("R6 no toggle unarmed", status6, o6);
  endtask

  task automatic t_program();
    logic o6;
    arm();
    o6 = status6;
    read_cycle(3'd0, 0);
    chk("R2 program toggle 1", status6, ~o6);
    read_cycle(3'd1, 0);
    chk("R2 program toggle 2", status6, o6);
    chk("R5 status2 still in program", status2, 1'b0);
  endtask

  task automatic t_delimit();
    logic o6;
    o6 = status6;
    read_cycle(3'd2, 1);
    chk("R3 ce closes read", status6, ~o6);
    read_cycle(3'd2, 0);
    chk("R3 oe closes read", status6, o6);
    set_state(3'd0);
    chk("R9 ready after completion", ready, 1'b1);
    o6 = status6;
    read_cycle(3'd0, 0);
    chk("R4 idle hold", status6, o6);
  endtask

  task automatic t_erase();
    logic o6, o2;
    erase_sel = 6'b000101;
    set_state(3'd2);
    arm();
    o6 = status6; o2 = status2;
    read_cycle(3'd0, 0);
    chk("R2 erase status6", status6, ~o6);
    chk("R5 selected sector status2", status2, ~o2);
    read_cycle(3'd1, 1);
    chk("R2 erase status6 again", status6, o6);
    chk("R5 unselected sector hold", status2, ~o2);
    erase_sel = 6'b111111;
    read_cycle(3'd6, 0);
    chk("R5 out of range hold", status2, ~o2);
    erase_sel = 6'b000101;
  endtask

  task automatic t_suspend();
    logic o6, o2;
    set_state(3'd3);
    chk("R9 ready in suspend", ready, 1'b1);
    o6 = status6; o2 = status2;
    read_cycle(3'd2, 0);
    chk("R4 suspend status6 hold", status6, o6);
    chk("R5 suspend selected toggle", status2, ~o2);
    read_cycle(3'd3, 0);
    chk("R5 suspend unselected hold", status2, ~o2);
    set_state(3'd0);
  endtask

  task automatic t_fault(logic [2:0] s, logic [2:0] after, logic exp_esp, string nm);
    set_state(s);
    arm();
    @(negedge clk); limit_hit = 1'b1;
    @(negedge clk); limit_hit = 1'b0;
    chk({"R7 status5 set ", nm}, status5, 1'b1);
    chk({"R7 busy on fault ", nm}, ready, 1'b0);
    @(negedge clk); op_state = after; reset_cmd = 1'b1;
    @(negedge clk); reset_cmd = 1'b0;
    chk({"R8 status5 cleared ", nm}, status5, 1'b0);
    chk({"R8 ret_valid ", nm}, ret_valid, 1'b1);
    chk({"R8 ret_esusp ", nm}, ret_esusp, exp_esp);
    chk({"R9 ready after reset ", nm}, ready, 1'b1);
    @(negedge clk);
    chk({"R8 ret_valid one cycle ", nm}, ret_valid, 1'b0);
    set_state(3'd0);
  endtask

  task automatic t_ignored();
    set_state(3'd0);
    @(negedge clk); limit_hit = 1'b1;
    @(negedge clk); limit_hit = 1'b0;
    chk("R10 idle limit ignored", status5, 1'b0);
    set_state(3'd3);
    @(negedge clk); limit_hit = 1'b1;
    @(negedge clk); limit_hit = 1'b0;
    chk("R10 suspend limit ignored", status5, 1'b0);
    @(negedge clk); reset_cmd = 1'b1;
    @(negedge clk); reset_cmd = 1'b0;
    chk("R8 reset without fault", ret_valid, 1'b0);
    set_state(3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_program();
    t_delimit();
    t_erase();
    t_suspend();
    t_fault(3'd1, 3'd0, 1'b0, "program");
    t_fault(3'd4, 3'd3, 1'b1, "suspended program");
    t_ignored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule